// File: doc/BRIEF.md
# Serial-Bus Control Register for a Satellite Supply Controller

This block is a two-wire serial (I2C) slave that owns a single 8-bit system register inside a supply and signalling controller for a satellite receiver front end. A host writes one byte to set six control bits: supply enable, output voltage select, cable-drop compensation, continuous tone enable, current-limit level select and pulsed current-limit mode. The same byte read back carries those six bits plus two live diagnostic flags, overload and over-temperature, taken at the moment each read byte starts.

The bus lines are oversampled by the system clock through synchronizers. START, STOP and the SCL edges are recovered from the sampled lines. The slave drives SDA only through an open-drain enable. Two strap inputs pick one of four 7-bit slave addresses. While the undervoltage-lockout input is high, the slave acknowledges nothing and commits nothing. A byte cut short by STOP or by a fresh START leaves the register as it was.

Top module: `sat_supply_i2c_ctl`

## Requirements
- R1: After reset all six control outputs are 0 and the SDA drive enable is 0.
- R2: The slave answers the 7-bit address 0b00010 followed by the two strap bits (strap[1] first), with the R/W bit (LSB of the first byte, 1 = read) after it. A first byte with a matching address is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge.
- R3: In a write, the first data byte after the address updates the control outputs once its eighth bit is received: ctrl_o[0] enable, [1] voltage select, [2] cable-drop compensation, [3] tone enable, [4] current-limit select, [5] pulsed-limit mode.
- R4: Bits 7 and 6 of a written data byte are ignored: they change no control output and do not appear in a later read.
- R5: A read returns, MSB first, the byte {overload, over-temperature, ctrl[5:0]}: bit 7 is overload and bit 6 is over-temperature, both sampled when the byte starts.
- R6: While the undervoltage input is high, no byte (address or data) is acknowledged and no written byte reaches the control outputs.
- R7: A STOP or a START that arrives before the eighth bit of a byte ends the transfer with the control outputs unchanged. A START always re-arms address reception.
- R8: Each data byte of a write is acknowledged, and every further data byte in the same transfer replaces the control bits again.
- R9: In a read, the slave sends another byte after the master acknowledges, and after a master not-acknowledge it releases SDA and stays idle until the next START.
- R10: SDA is driven only in an acknowledge slot or while read data is shifted out. Its drive changes only after SCL falls, or at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_strap_i | input | 2 | Selects the low two address bits |
| uvlo_i | input | 1 | Undervoltage lockout, high suppresses acknowledge and writes |
| overload_i | input | 1 | Live overload diagnostic flag |
| overtemp_i | input | 1 | Live over-temperature diagnostic flag |
| ctrl_o | output | 6 | Control bits: enable, voltage select, cable compensation, tone, current-limit select, pulsed mode |

## Verification
The bench drives single and multi-byte writes, so acknowledge timing and bit placement are checked separately from the replacement of earlier values. Writes with the top two bits set, followed by reads with the flags held low, show whether those bits leak into storage. Reads with the two flags set in different combinations show that bits 7 and 6 are live and in the right order. All four strap values are tried with both matching and neighbouring addresses. Undervoltage on the address byte and on a data byte, and bytes cut off by STOP or by START, show that acknowledge and commit are both suppressed.

// File: rtl/sat_supply_pkg.sv
package sat_supply_pkg;
  localparam int REG_W   = 8;
  localparam int CTRL_W  = 6;
  localparam int STRAP_W = 2;
  localparam int ADDR_W  = 7;
  localparam int BASE_W  = ADDR_W - STRAP_W;
  localparam logic [BASE_W-1:0] ADDR_BASE = 5'b00010;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_ACKW,
    SL_ACK,
    SL_RX,
    SL_TX,
    SL_MACK,
    SL_MACKF
  } sl_state_t;

  // First byte carries address in [7:1], R/W in [0].
  function automatic logic addr_hit(input logic [REG_W-1:0] first,
                                    input logic [STRAP_W-1:0] strap);
    return first[REG_W-1:1] == {ADDR_BASE, strap};
  endfunction

  // Read image: overload on top, over-temperature next, control bits below.
  function automatic logic [REG_W-1:0] read_image(input logic olf,
                                                  input logic otf,
                                                  input logic [CTRL_W-1:0] ctrl);
    return {olf, otf, ctrl};
  endfunction

  // Only the low control field of a written byte is kept.
  function automatic logic [CTRL_W-1:0] write_field(input logic [REG_W-1:0] b);
    return b[CTRL_W-1:0];
  endfunction
endpackage

// File: rtl/sat_line_sync.sv
module sat_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic uvlo_raw,
  input  logic olf_raw,
  input  logic otf_raw,
  output logic scl_s,
  output logic sda_s,
  output logic uvlo_s,
  output logic olf_s,
  output logic otf_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] IDLE_LVL = 5'b00011;

  logic [NSIG-1:0] raw;
  logic            scl_p, sda_p;

  assign raw = {otf_raw, olf_raw, uvlo_raw, sda_raw, scl_raw};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [NSIG-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_LVL;
        else        q <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_LVL;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign {otf_s, olf_s, uvlo_s, sda_s, scl_s} = g_stage[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/sat_slave_fsm.sv
module sat_slave_fsm
  import sat_supply_pkg::*;
#(
  parameter int BYTE_W = REG_W,
  parameter int SW     = STRAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              uvlo_s,
  input  logic [SW-1:0]     strap,
  input  logic [BYTE_W-1:0] rd_word,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  sl_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw_read;
  logic              master_ack;

  // Named internal events for the assertions.
  logic [BYTE_W-1:0] rx_full;
  logic              byte_end;
  logic              ack_slot;
  assign rx_full  = {sh[BYTE_W-2:0], sda_s};
  assign byte_end = scl_rise && (bit_cnt == LAST_BIT);
  assign ack_slot = (state == SL_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SL_IDLE;
      bit_cnt    <= '0;
      sh         <= '0;
      rw_read    <= 1'b0;
      master_ack <= 1'b0;
      sda_oe     <= 1'b0;
      wr_strobe  <= 1'b0;
      wr_byte    <= '0;
    end else begin
      wr_strobe <= 1'b0;
      if (start_evt) begin
        state   <= SL_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= SL_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          SL_IDLE: ;
          SL_ADDR: begin
            if (scl_rise) begin
              sh      <= rx_full;
              bit_cnt <= bit_cnt + 1'b1;
              if (byte_end) begin
                if (addr_hit(rx_full, strap) && !uvlo_s) begin
                  rw_read <= sda_s;
                  state   <= SL_ACKW;
                end else begin
                  state <= SL_IDLE;
                end
              end
            end
          end
          SL_RX: begin
            if (scl_rise) begin
              sh      <= rx_full;
              bit_cnt <= bit_cnt + 1'b1;
              if (byte_end) begin
                if (!uvlo_s) begin
                  wr_strobe <= 1'b1;
                  wr_byte   <= rx_full;
                  state     <= SL_ACKW;
                end else begin
                  state <= SL_IDLE;
                end
              end
            end
          end
          SL_ACKW: begin
            if (scl_fall) begin
              sda_oe <= 1'b1;
              state  <= SL_ACK;
            end
          end
          SL_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_read) begin
                sh     <= rd_word;
                sda_oe <= ~rd_word[BYTE_W-1];
                state  <= SL_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= SL_RX;
              end
            end
          end
          SL_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= SL_MACK;
              end else begin
                sda_oe  <= ~sh[BYTE_W-2];
                sh      <= sh << 1;
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          SL_MACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
              state      <= SL_MACKF;
            end
          end
          SL_MACKF: begin
            if (scl_fall) begin
              if (master_ack) begin
                sh      <= rd_word;
                sda_oe  <= ~rd_word[BYTE_W-1];
                bit_cnt <= '0;
                state   <= SL_TX;
              end else begin
                state <= SL_IDLE;
              end
            end
          end
          default: state <= SL_IDLE;
        endcase
      end
    end
  end

  // R10: drive only in an acknowledge slot or while shifting read data.
  p_oe_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (ack_slot || state == SL_TX));

  // R10: drive changes only after SCL falls or on START/STOP.
  p_oe_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R6: a commit is never issued while undervoltage was seen.
  p_no_commit_uvlo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> !$past(uvlo_s));

  // R7: START always re-arms address reception with SDA released.
  p_start_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == SL_ADDR && bit_cnt == '0 && !sda_oe));

  // R9: after a master not-acknowledge the slave goes idle.
  p_nack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SL_MACKF && scl_fall && !master_ack && !start_evt && !stop_evt)
      |=> (state == SL_IDLE && !sda_oe));
endmodule

// File: rtl/sat_reg_bank.sv
module sat_reg_bank
  import sat_supply_pkg::*;
#(
  parameter int BYTE_W = REG_W,
  parameter int CW     = CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              olf_s,
  input  logic              otf_s,
  output logic [CW-1:0]     ctrl_q,
  output logic [BYTE_W-1:0] rd_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (wr_strobe) ctrl_q <= write_field(wr_byte);
  end

  assign rd_word = read_image(olf_s, otf_s, ctrl_q);

  // R1: control bits come out of reset cleared.
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (ctrl_q == '0));

  // R7: without a commit the control bits hold.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(ctrl_q));

  // R4: a commit copies exactly the low field of the received byte.
  p_low_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> (ctrl_q == $past(wr_byte[CW-1:0])));
endmodule

// File: rtl/sat_supply_i2c_ctl.sv
module sat_supply_i2c_ctl
  import sat_supply_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] addr_strap_i,
  input  logic               uvlo_i,
  input  logic               overload_i,
  input  logic               overtemp_i,
  output logic [CTRL_W-1:0]  ctrl_o
);
  logic scl_s, sda_s, uvlo_s, olf_s, otf_s;
  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic wr_strobe;
  logic [REG_W-1:0] wr_byte, rd_word;

  sat_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .uvlo_raw  (uvlo_i),
    .olf_raw   (overload_i),
    .otf_raw   (overtemp_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .uvlo_s    (uvlo_s),
    .olf_s     (olf_s),
    .otf_s     (otf_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  sat_slave_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .uvlo_s    (uvlo_s),
    .strap     (addr_strap_i),
    .rd_word   (rd_word),
    .sda_oe    (sda_oe_o),
    .wr_strobe (wr_strobe),
    .wr_byte   (wr_byte)
  );

  sat_reg_bank u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .wr_byte   (wr_byte),
    .olf_s     (olf_s),
    .otf_s     (otf_s),
    .ctrl_q    (ctrl_o),
    .rd_word   (rd_word)
  );
endmodule

// File: tb/sim_sat_supply_i2c_ctl.sv
`timescale 1ns/1ps
module sim_sat_supply_i2c_ctl;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'd2;
  logic       uvlo = 1'b0;
  logic       ovl = 1'b0;
  logic       otmp = 1'b0;
  logic       sda_oe;
  logic [5:0] ctrl;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  sat_supply_i2c_ctl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .addr_strap_i (strap),
    .uvlo_i       (uvlo),
    .overload_i   (ovl),
    .overtemp_i   (otmp),
    .ctrl_o       (ctrl)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int         exp_req[$];
  logic [7:0] exp_val[$];
  logic [7:0] obs_val[$];

  task automatic push_exp(input int r, input logic [7:0] v);
    exp_req.push_back(r);
    exp_val.push_back(v);
  endtask

  task automatic push_obs(input logic [7:0] v);
    obs_val.push_back(v);
  endtask

  // Monitor: pairs observed results with expected items in order.
  always @(negedge clk) begin
    while (obs_val.size() > 0 && exp_val.size() > 0) begin
      int         r;
      logic [7:0] e, o;
      r = exp_req.pop_front();
      e = exp_val.pop_front();
      o = obs_val.pop_front();
      compared++;
      if (o !== e) begin
        mismatched++;
        $display("FAIL R%0d: got 0x%02h expected 0x%02h", r, o, e);
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; wq();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 1'b0; wq();
      sda_m = b[i]; wq();
      scl = 1'b1; wq(); wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    scl = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    ack = ~sda_bus;
    wq();
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0;
      sda_m = 1'b1;
      wq(); wq();
      scl = 1'b1; wq();
      b[i] = sda_bus;
      wq();
    end
    scl = 1'b0; wq();
    sda_m = m_ack ? 1'b0 : 1'b1; wq();
    scl = 1'b1; wq(); wq();
  endtask

  task automatic check_ack(input int r, input logic got, input logic want);
    push_exp(r, {7'd0, want});
    push_obs({7'd0, got});
  endtask

  task automatic check_ctrl(input int r, input logic [5:0] want);
    push_exp(r, {2'b00, want});
    push_obs({2'b00, ctrl});
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d,
                           input int r, input logic want_ack);
    logic ack;
    bus_start();
    send_byte(a, ack);
    check_ack(2, ack, 1'b1);                 // R2 address acknowledged
    send_byte(d, ack);
    check_ack(r, ack, want_ack);
    bus_stop();
  endtask

  initial begin
    logic       ack;
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_ctrl(1, 6'h00);
    check_ack(1, sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_ctrl(1, 6'h00);

    // R3 / R8: two data bytes in one write, both acked, last one kept
    bus_start();
    send_byte(8'h14, ack); check_ack(2, ack, 1'b1);
    send_byte(8'h12, ack); check_ack(8, ack, 1'b1);
    repeat (10) @(negedge clk);
    check_ctrl(3, 6'h12);                    // R3 after eighth bit
    send_byte(8'h2D, ack); check_ack(8, ack, 1'b1);
    bus_stop();
    check_ctrl(8, 6'h2D);                    // R8 second byte replaces

    // R4: top two bits dropped
    write_reg(8'h14, 8'hC5, 8, 1'b1);
    check_ctrl(4, 6'h05);

    // R5 / R9: read with flags, master acks then nacks
    ovl = 1'b0; otmp = 1'b0;
    repeat (10) @(negedge clk);
    bus_start();
    send_byte(8'h15, ack); check_ack(2, ack, 1'b1);
    recv_byte(1'b1, rb);
    push_exp(4, 8'h05); push_obs(rb);        // R4 written top bits not stored
    ovl = 1'b1;
    recv_byte(1'b1, rb);
    push_exp(5, 8'h85); push_obs(rb);        // R5 overload in bit 7
    ovl = 1'b0; otmp = 1'b1;
    recv_byte(1'b0, rb);
    push_exp(9, 8'h45); push_obs(rb);        // R9 further byte after ack
    wq();
    check_ack(9, sda_oe, 1'b0);              // R9 released after nack
    bus_stop();
    check_ack(10, sda_oe, 1'b0);             // R10 idle bus not driven
    otmp = 1'b0;

    // R2: all four straps, matching and neighbouring addresses
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      repeat (10) @(negedge clk);
      bus_start();
      send_byte({5'b00010, 2'(s ^ 1), 1'b0}, ack);
      check_ack(2, ack, 1'b0);               // R2 wrong address ignored
      bus_stop();
      write_reg({5'b00010, 2'(s), 1'b0}, 8'h08 + 8'(s), 8, 1'b1);
      check_ctrl(2, 6'h08 + 6'(s));
    end

    // R6: undervoltage on the address byte
    uvlo = 1'b1;
    repeat (10) @(negedge clk);
    bus_start();
    send_byte(8'h16, ack); check_ack(6, ack, 1'b0);
    bus_stop();
    // R6: undervoltage rising before the data byte
    uvlo = 1'b0;
    repeat (10) @(negedge clk);
    bus_start();
    send_byte(8'h16, ack); check_ack(2, ack, 1'b1);
    uvlo = 1'b1;
    send_byte(8'h3F, ack); check_ack(6, ack, 1'b0);
    bus_stop();
    check_ctrl(6, 6'h0B);
    uvlo = 1'b0;
    repeat (10) @(negedge clk);

    // R7: STOP in mid-byte
    bus_start();
    send_byte(8'h16, ack); check_ack(2, ack, 1'b1);
    send_bits(8'h3F, 5);
    bus_stop();
    check_ctrl(7, 6'h0B);
    // R7: START in mid-byte, then a full write is accepted
    bus_start();
    send_byte(8'h16, ack); check_ack(2, ack, 1'b1);
    send_bits(8'h3F, 4);
    check_ctrl(7, 6'h0B);
    bus_start();
    send_byte(8'h16, ack); check_ack(7, ack, 1'b1);
    send_byte(8'h21, ack); check_ack(8, ack, 1'b1);
    bus_stop();
    check_ctrl(7, 6'h21);

    repeat (20) @(negedge clk);
    if (exp_val.size() != obs_val.size()) begin
      mismatched++;
      $display("FAIL R0: queue sizes %0d observed vs %0d expected",
               obs_val.size(), exp_val.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R0: watchdog expired, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule